// File: doc/BRIEF.md
# Interval Unfairness Evaluator

This block watches inter-core interference in a four-core shared memory system over fixed accounting intervals. Every cycle an upstream detector may report one interference event that names a victim core and the core that delayed it. The block keeps an excess-cycle count per victim and a count for every ordered (aggressor, victim) pair. When an interval closes, it estimates each core's slowdown. The estimated alone-run time is the interval length minus that core's excess cycles, and the slowdown is the interval length divided by that alone time, scaled by a per-core priority weight.

A short evaluation walk then finds the most and least slowed cores and compares their ratio with a programmable target. It also picks the core that caused the most interference to the most slowed core. The result is presented with a one-cycle strobe and held until the next one. A throttling controller uses the over-target flag and the two core IDs to slow down the aggressor and speed up the victim.

The controller is a four-state machine. ACCUM counts INTERVAL_LEN cycles and accepts events. SCAN_SD walks the cores once to find the largest and smallest weighted slowdowns. SCAN_AGG walks the aggressor counters of the slowest core. REPORT publishes the result, clears every counter and returns to ACCUM. The named transitions are:
- ACCUM→SCAN_SD on the last interval cycle.
- SCAN_SD→SCAN_AGG and SCAN_AGG→REPORT after the last core index.
- REPORT→ACCUM always.

All ratios are compared by cross-multiplication, so the block has no divider.

Top module: `unfairness_eval`

## Requirements
- R1: While reset is asserted, and after it until the first result, eval_valid, over_target, slowest_id and aggressor_id are all 0.
- R2: Each interval has INTERVAL_LEN accumulation cycles followed by 2·NCORES+1 evaluation cycles. eval_valid is a one-cycle pulse every INTERVAL_LEN+2·NCORES+1 cycles. The first pulse comes that many cycles after reset release. The three result outputs change only together with the pulse.
- R3: A core's excess counter grows by one on each accumulation cycle that carries a valid event naming it as victim with a different aggressor. It saturates at INTERVAL_LEN−1, so the estimated alone time is never below 1.
- R4: An event whose victim equals its aggressor changes no counter.
- R5: The weighted slowdown of core i is W_i·L/(L−E_i), where L is INTERVAL_LEN and E_i is its excess count. W_i is the unsigned 8-bit value at bits [8i+7:8i] of weights. slowest_id is the core with the largest weighted slowdown, and a tie goes to the lowest index.
- R6: The smallest weighted slowdown, with ties to the lowest index, is the denominator of the unfairness ratio.
- R7: aggressor_id is the core j≠slowest_id with the largest pair count for (aggressor j, victim slowest_id), and a tie goes to the lowest index. When all such counts are zero it is the lowest index other than slowest_id, so it never equals slowest_id.
- R8: over_target is 1 exactly when max slowdown / min slowdown > target_q/256 strictly, where target_q is unsigned with 8 fraction bits.
- R9: All counters restart from zero at each interval, so each result depends only on the events of its own interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An interference event is present this cycle |
| ev_victim | input | $clog2(NCORES) | Core that was delayed |
| ev_aggr | input | $clog2(NCORES) | Core that caused the delay |
| target_q | input | TGT_W | Unfairness target, unsigned, TGT_FRAC fraction bits |
| weights | input | NCORES·WEIGHT_W | Per-core priority weights, core i in slice i |
| eval_valid | output | 1 | One-cycle strobe: new result |
| over_target | output | 1 | Estimated unfairness exceeds target |
| slowest_id | output | $clog2(NCORES) | Core with the largest weighted slowdown |
| aggressor_id | output | $clog2(NCORES) | Core that interfered most with slowest_id |

## Verification
The assertions check the interval rhythm on every cycle: the strobe is one cycle wide and arrives exactly on schedule, the results stay still between strobes, no excess counter passes its saturation value, and the reported aggressor differs from the slowest core. Only the bench's scenarios can show the arithmetic. These cover which core wins the weighted maximum, how slowdown ties and all-zero aggressor rows resolve, that self-events are dropped, that counters restart each interval, and where the strict comparison against the target flips, including a saturated alone time.

// File: rtl/uf_pkg.sv
package uf_pkg;
    typedef enum logic [1:0] {
        ST_ACCUM    = 2'd0,
        ST_SCAN_SD  = 2'd1,
        ST_SCAN_AGG = 2'd2,
        ST_REPORT   = 2'd3
    } uf_state_e;
endpackage

// File: rtl/uf_ratio_gt.sv
// Unsigned comparison a*b > c*d, computed at a common width.
module uf_ratio_gt #(
    parameter int AW = 8,
    parameter int BW = 8,
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic [CW-1:0] c,
    input  logic [DW-1:0] d,
    output logic          gt
);
    localparam int LW = AW + BW;
    localparam int RW = CW + DW;
    localparam int PW = (LW > RW) ? LW : RW;

    logic [PW-1:0] lhs, rhs;

    always_comb begin
        lhs = PW'(a) * PW'(b);
        rhs = PW'(c) * PW'(d);
        gt  = lhs > rhs;
    end
endmodule

// File: rtl/uf_counter_bank.sv
// Per-victim excess counters and aggressor-by-victim pair counters.
module uf_counter_bank #(
    parameter int NCORES = 4,
    parameter int CNT_W  = 11,
    parameter int SAT    = 1023,
    localparam int IDW   = $clog2(NCORES)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   clear,
    input  logic                                   ev_en,
    input  logic [IDW-1:0]                         victim,
    input  logic [IDW-1:0]                         aggr,
    output logic [NCORES-1:0][CNT_W-1:0]           excess_o,
    output logic [NCORES-1:0][NCORES-1:0][CNT_W-1:0] pair_o
);
    logic hit;
    assign hit = ev_en && (victim != aggr);

    for (genvar gv = 0; gv < NCORES; gv++) begin : g_victim
        logic [CNT_W-1:0] ex_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ex_q <= '0;
            end else if (clear) begin
                ex_q <= '0;
            end else if (hit && victim == IDW'(gv) && ex_q != CNT_W'(SAT)) begin
                ex_q <= ex_q + CNT_W'(1);
            end
        end
        assign excess_o[gv] = ex_q;

        for (genvar ga = 0; ga < NCORES; ga++) begin : g_aggr
            if (ga == gv) begin : g_diag
                assign pair_o[ga][gv] = '0;
            end else begin : g_cnt
                logic [CNT_W-1:0] pc_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        pc_q <= '0;
                    end else if (clear) begin
                        pc_q <= '0;
                    end else if (hit && victim == IDW'(gv) && aggr == IDW'(ga)) begin
                        pc_q <= pc_q + CNT_W'(1);
                    end
                end
                assign pair_o[ga][gv] = pc_q;
            end
        end
    end
endmodule

// File: rtl/unfairness_eval.sv
module unfairness_eval
    import uf_pkg::*;
#(
    parameter int NCORES       = 4,
    parameter int INTERVAL_LEN = 1024,
    parameter int WEIGHT_W     = 8,
    parameter int TGT_W        = 16,
    parameter int TGT_FRAC     = 8,
    localparam int IDW         = $clog2(NCORES),
    localparam int CNT_W       = $clog2(INTERVAL_LEN + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ev_valid,
    input  logic [IDW-1:0]             ev_victim,
    input  logic [IDW-1:0]             ev_aggr,
    input  logic [TGT_W-1:0]           target_q,
    input  logic [NCORES*WEIGHT_W-1:0] weights,
    output logic                       eval_valid,
    output logic                       over_target,
    output logic [IDW-1:0]             slowest_id,
    output logic [IDW-1:0]             aggressor_id
);
    localparam logic [IDW-1:0]   LAST_IDX = IDW'(NCORES - 1);
    localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(INTERVAL_LEN - 1);
    localparam int               MW       = WEIGHT_W + CNT_W;

    uf_state_e state_q, state_d;
    logic [CNT_W-1:0] cyc_q, best_q;
    logic [IDW-1:0]   idx_q, max_q, min_q, agg_q;
    logic             have_q;

    logic [NCORES-1:0][CNT_W-1:0]             excess;
    logic [NCORES-1:0][NCORES-1:0][CNT_W-1:0] pair;
    logic [CNT_W-1:0]    alone [NCORES];
    logic [WEIGHT_W-1:0] wgt   [NCORES];
    logic [WEIGHT_W-1:0] w_cur, w_max, w_min;
    logic [CNT_W-1:0]    a_cur, a_max, a_min, pair_cand;
    logic [MW-1:0]       wmin_amax;
    logic                cur_above_max, cur_below_min, unfair_over;

    uf_counter_bank #(
        .NCORES(NCORES), .CNT_W(CNT_W), .SAT(INTERVAL_LEN - 1)
    ) counters_i (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q == ST_REPORT),
        .ev_en(ev_valid && state_q == ST_ACCUM),
        .victim(ev_victim), .aggr(ev_aggr),
        .excess_o(excess), .pair_o(pair)
    );

    always_comb begin
        for (int k = 0; k < NCORES; k++) begin
            alone[k] = CNT_W'(INTERVAL_LEN) - excess[k];
            wgt[k]   = weights[k*WEIGHT_W +: WEIGHT_W];
        end
        w_cur     = wgt[idx_q];
        a_cur     = alone[idx_q];
        w_max     = wgt[max_q];
        a_max     = alone[max_q];
        w_min     = wgt[min_q];
        a_min     = alone[min_q];
        pair_cand = pair[idx_q][max_q];
        wmin_amax = MW'(w_min) * MW'(a_max);
    end

    // current core's slowdown strictly above the running maximum
    uf_ratio_gt #(.AW(WEIGHT_W), .BW(CNT_W), .CW(WEIGHT_W), .DW(CNT_W)) cmp_max_i (
        .a(w_cur), .b(a_max), .c(w_max), .d(a_cur), .gt(cur_above_max));

    // current core's slowdown strictly below the running minimum
    uf_ratio_gt #(.AW(WEIGHT_W), .BW(CNT_W), .CW(WEIGHT_W), .DW(CNT_W)) cmp_min_i (
        .a(w_min), .b(a_cur), .c(w_cur), .d(a_min), .gt(cur_below_min));

    // max/min ratio strictly above target
    uf_ratio_gt #(.AW(WEIGHT_W + TGT_FRAC), .BW(CNT_W), .CW(TGT_W), .DW(MW)) cmp_tgt_i (
        .a({w_max, {TGT_FRAC{1'b0}}}), .b(a_min), .c(target_q), .d(wmin_amax),
        .gt(unfair_over));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACCUM;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM:    if (cyc_q == LAST_CYC) state_d = ST_SCAN_SD;
            ST_SCAN_SD:  if (idx_q == LAST_IDX) state_d = ST_SCAN_AGG;
            ST_SCAN_AGG: if (idx_q == LAST_IDX) state_d = ST_REPORT;
            ST_REPORT:   state_d = ST_ACCUM;
            default:     state_d = ST_ACCUM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            idx_q  <= '0;
            max_q  <= '0;
            min_q  <= '0;
            agg_q  <= '0;
            best_q <= '0;
            have_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ACCUM: begin
                    cyc_q <= (cyc_q == LAST_CYC) ? '0 : cyc_q + CNT_W'(1);
                    idx_q <= '0;
                end
                ST_SCAN_SD: begin
                    if (idx_q == '0) begin
                        max_q <= '0;
                        min_q <= '0;
                    end else begin
                        if (cur_above_max) max_q <= idx_q;
                        if (cur_below_min) min_q <= idx_q;
                    end
                    have_q <= 1'b0;
                    idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + IDW'(1);
                end
                ST_SCAN_AGG: begin
                    if (idx_q != max_q && (!have_q || pair_cand > best_q)) begin
                        agg_q  <= idx_q;
                        best_q <= pair_cand;
                        have_q <= 1'b1;
                    end
                    idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDW'(1);
                end
                ST_REPORT: begin
                    idx_q <= '0;
                end
                default: idx_q <= '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eval_valid   <= 1'b0;
            over_target  <= 1'b0;
            slowest_id   <= '0;
            aggressor_id <= '0;
        end else begin
            eval_valid <= (state_q == ST_REPORT);
            if (state_q == ST_REPORT) begin
                over_target  <= unfair_over;
                slowest_id   <= max_q;
                aggressor_id <= agg_q;
            end
        end
    end
endmodule

// File: rtl/uf_checker.sv
module uf_checker #(
    parameter int NCORES       = 4,
    parameter int INTERVAL_LEN = 1024,
    localparam int IDW         = $clog2(NCORES),
    localparam int CNT_W       = $clog2(INTERVAL_LEN + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         eval_valid,
    input logic                         over_target,
    input logic [IDW-1:0]               slowest_id,
    input logic [IDW-1:0]               aggressor_id,
    input logic [NCORES-1:0][CNT_W-1:0] excess
);
    localparam int PERIOD = INTERVAL_LEN + 2 * NCORES + 1;
    localparam int GW     = $clog2(PERIOD + 1) + 1;

    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          gap_q <= '0;
        else if (eval_valid) gap_q <= GW'(1);
        else                 gap_q <= gap_q + GW'(1);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!eval_valid && !over_target && slowest_id == '0 && aggressor_id == '0); // R1
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eval_valid |=> !eval_valid); // R2
    AST_PERIOD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        eval_valid |-> gap_q == GW'(PERIOD)); // R2
    AST_NO_LATE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q == GW'(PERIOD) |-> eval_valid); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_valid |-> ($stable(over_target) && $stable(slowest_id) && $stable(aggressor_id))); // R2
    AST_AGGR_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        eval_valid |-> slowest_id != aggressor_id); // R7

    for (genvar g = 0; g < NCORES; g++) begin : g_ex
        AST_EXCESS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
            excess[g] <= CNT_W'(INTERVAL_LEN - 1)); // R3
    end
endmodule

bind unfairness_eval uf_checker #(
    .NCORES(NCORES), .INTERVAL_LEN(INTERVAL_LEN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .eval_valid(eval_valid), .over_target(over_target),
    .slowest_id(slowest_id), .aggressor_id(aggressor_id), .excess(excess)
);

// File: tb/unfairness_eval_tb_top.sv
`timescale 1ns/1ps
module unfairness_eval_tb_top;
    localparam int LEN    = 16;
    localparam int NC     = 4;
    localparam int PERIOD = LEN + 2 * NC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_victim = '0;
    logic [1:0]  ev_aggr = '0;
    logic [15:0] target_q = 16'd128;
    logic [31:0] weights = 32'h01010101;
    logic        eval_valid, over_target;
    logic [1:0]  slowest_id, aggressor_id;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    unfairness_eval #(.NCORES(NC), .INTERVAL_LEN(LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_victim(ev_victim),
        .ev_aggr(ev_aggr), .target_q(target_q), .weights(weights),
        .eval_valid(eval_valid), .over_target(over_target),
        .slowest_id(slowest_id), .aggressor_id(aggressor_id));

    typedef struct packed {
        logic [1:0]  va; logic [1:0] aa; logic [4:0] na;
        logic [1:0]  vb; logic [1:0] ab; logic [4:0] nb;
        logic [31:0] w;  logic [15:0] tq;
        logic        ov; logic [1:0] sl; logic [1:0] ag;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 2'd1, 5'd8,  2'd0, 2'd3, 5'd2, 32'h01010101, 16'd384,  1'b1, 2'd2, 2'd1}, // R5 R8
        '{2'd2, 2'd1, 5'd8,  2'd0, 2'd3, 5'd2, 32'h01010101, 16'd512,  1'b0, 2'd2, 2'd1}, // R8 strict, R9
        '{2'd1, 2'd0, 5'd4,  2'd1, 2'd3, 5'd4, 32'h01010101, 16'd511,  1'b1, 2'd1, 2'd0}, // R7 tie
        '{2'd3, 2'd2, 5'd4,  2'd0, 2'd0, 5'd0, 32'h01010102, 16'd384,  1'b1, 2'd0, 2'd1}, // R5 weights
        '{2'd1, 2'd2, 5'd6,  2'd3, 2'd0, 5'd6, 32'h01010101, 16'd409,  1'b1, 2'd1, 2'd2}, // R5 tie
        '{2'd0, 2'd0, 5'd10, 2'd3, 2'd1, 5'd4, 32'h01010101, 16'd256,  1'b1, 2'd3, 2'd1}, // R4
        '{2'd2, 2'd0, 5'd16, 2'd0, 2'd0, 5'd0, 32'h01010101, 16'd4096, 1'b0, 2'd2, 2'd0}, // R3 sat
        '{2'd0, 2'd0, 5'd0,  2'd0, 2'd0, 5'd0, 32'h01020401, 16'd1023, 1'b1, 2'd1, 2'd0}  // R6 R7
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] v, input logic [1:0] a, input int n);
        for (int k = 0; k < n; k++) begin
            ev_valid  = 1'b1;
            ev_victim = v;
            ev_aggr   = a;
            @(negedge clk);
        end
        ev_valid = 1'b0;
    endtask

    task automatic wait_valid();
        @(negedge clk);
        while (!eval_valid) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 valid in reset", int'(eval_valid), 0);
        chk("R1 over in reset", int'(over_target), 0);
        chk("R1 ids in reset", int'({slowest_id, aggressor_id}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 quiet before first result", int'({eval_valid, over_target, slowest_id, aggressor_id}), 0);

        // idle interval: equal slowdowns, all-zero aggressor row, target 0.5
        wait_valid();
        chk("R7 idle slowest", int'(slowest_id), 0);
        chk("R7 idle aggressor", int'(aggressor_id), 1);
        chk("R8 idle over", int'(over_target), 1);

        for (int i = 0; i < NV; i++) begin
            weights  = VECS[i].w;
            target_q = VECS[i].tq;
            drive(VECS[i].va, VECS[i].aa, int'(VECS[i].na));
            drive(VECS[i].vb, VECS[i].ab, int'(VECS[i].nb));
            wait_valid();
            chk($sformatf("R5 R6 R9 vec%0d slowest", i), int'(slowest_id), int'(VECS[i].sl));
            chk($sformatf("R7 R4 vec%0d aggressor", i), int'(aggressor_id), int'(VECS[i].ag));
            chk($sformatf("R8 R3 vec%0d over", i), int'(over_target), int'(VECS[i].ov));
        end

        // directed: pulse width, hold and period (last results were 1,1,0)
        begin
            int gap;
            gap = 0;
            @(negedge clk);
            chk("R2 pulse one cycle", int'(eval_valid), 0);
            repeat (5) @(negedge clk);
            chk("R2 results held", int'({over_target, slowest_id, aggressor_id}), 5'b10100);
            gap = 6;
            while (!eval_valid) begin
                @(negedge clk);
                gap++;
            end
            chk("R2 period", gap, PERIOD);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule